// File: doc/BRIEF.md
# Logarithmic Shift/Rotate Unit

This block is a purely combinational word shifter for a datapath. It takes a data word, a shift distance and an operation selector. In the same cycle it returns the word shifted left or right, or rotated, by the requested number of positions. The shift distance can come straight from a register, so the unit handles variable shifts as well as constant ones.

Internally the distance is applied in binary-weighted steps. There is one layer of two-way selectors per bit of the distance. The layer driven by distance bit k either passes its input through or moves it by 2^k positions. The five operations share this single chain of layers. They differ only in the value written into the vacated positions: zeros, copies of the sign bit, or the bits that leave the opposite end.

The block has no clock and no state, so it has no flow control of its own. It is meant to sit between pipeline registers that the surrounding stage already qualifies with valid/ready. The result is combinationally valid whenever the inputs are.

Top module: `shf_unit`

## Requirements
- R1: Bit k of `shamt_i` moves the word by exactly 2^k positions, and the set bits combine additively, so the total distance equals the binary value of `shamt_i`.
- R2: With `op_i` = 3'b000 (logical left shift), `data_o` equals `data_i` moved toward the MSB by `shamt_i` places, with zeros entering at the LSB end.
- R3: With `op_i` = 3'b001 (logical right shift), `data_o` equals `data_i` moved toward the LSB by `shamt_i` places, with zeros entering at the MSB end.
- R4: With `op_i` = 3'b010 (arithmetic right shift), `data_o` is the right shift in which every vacated upper position takes the value of `data_i[WIDTH-1]`.
- R5: With `op_i` = 3'b011 (left rotate), the bits leaving the MSB end re-enter at the LSB end, and no bit is lost.
- R6: With `op_i` = 3'b100 (right rotate), the bits leaving the LSB end re-enter at the MSB end, and no bit is lost.
- R7: `op_i` values 3'b101, 3'b110 and 3'b111 return `data_i` unchanged for any `shamt_i`.
- R8: A `shamt_i` of zero returns `data_i` unchanged for every `op_i` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WIDTH (32) | Word to be shifted or rotated |
| shamt_i | input | log2(WIDTH) (5) | Shift or rotate distance, unsigned |
| op_i | input | 3 | Operation selector, encoded as listed in R2 to R7 |
| data_o | output | WIDTH (32) | Shifted or rotated result |

## Verification
The assertions are immediate checks made whenever the combinational inputs change. They assume that all three inputs are two-valued and stable while `data_o` is observed. The bench meets this by driving fully defined values on the falling clock edge and reading the result half a period later. The bench sweeps all eight operation codes and every distance from 0 to 31 over several data patterns. These patterns include both sign polarities and alternating-bit words, so each fill rule and each wrap-around path is exercised at every stage.

// File: rtl/shf_pkg.sv
package shf_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    SHF_SLL = 3'b000,
    SHF_SRL = 3'b001,
    SHF_SRA = 3'b010,
    SHF_ROL = 3'b011,
    SHF_ROR = 3'b100
  } shf_op_e;

  typedef struct packed {
    logic left;   // direction toward MSB
    logic rot;    // wrap shifted-out bits
    logic arith;  // replicate sign on right shift
    logic pass;   // return input untouched
  } shf_ctl_t;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output shf_ctl_t        ctl_o
);

  always_comb begin
    ctl_o = '{left: 1'b0, rot: 1'b0, arith: 1'b0, pass: 1'b0};
    case (op_i)
      SHF_SLL: ctl_o.left  = 1'b1;
      SHF_SRL: ;
      SHF_SRA: ctl_o.arith = 1'b1;
      SHF_ROL: begin
        ctl_o.left = 1'b1;
        ctl_o.rot  = 1'b1;
      end
      SHF_ROR: ctl_o.rot   = 1'b1;
      default: ctl_o.pass  = 1'b1;
    endcase
  end

endmodule

// File: rtl/shf_stage.sv
module shf_stage
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic             en_i,
  input  logic             sign_i,
  input  shf_ctl_t         ctl_i,
  output logic [WIDTH-1:0] y_o
);

  logic [DIST-1:0]  lo_fill;
  logic [DIST-1:0]  hi_fill;
  logic [WIDTH-1:0] moved;

  // Bits entering at the LSB end on a left move
  assign lo_fill = ctl_i.rot ? x_i[WIDTH-1:WIDTH-DIST] : '0;

  // Bits entering at the MSB end on a right move
  always_comb begin
    if (ctl_i.rot)        hi_fill = x_i[DIST-1:0];
    else if (ctl_i.arith) hi_fill = {DIST{sign_i}};
    else                  hi_fill = '0;
  end

  assign moved = ctl_i.left ? {x_i[WIDTH-DIST-1:0], lo_fill}
                            : {hi_fill, x_i[WIDTH-1:DIST]};

  assign y_o = en_i ? moved : x_i;

endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] shamt_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] data_o
);

  shf_ctl_t         ctl;
  logic [WIDTH-1:0] chain [AMT_W+1];

  shf_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  assign chain[0] = data_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    shf_stage #(
      .WIDTH (WIDTH),
      .DIST  (1 << k)
    ) u_stage (
      .x_i    (chain[k]),
      .en_i   (shamt_i[k]),
      .sign_i (data_i[WIDTH-1]),
      .ctl_i  (ctl),
      .y_o    (chain[k+1])
    );
  end

  assign data_o = ctl.pass ? data_i : chain[AMT_W];

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] data_i,
  input logic [AMT_W-1:0] shamt_i,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] data_o
);

  always_comb begin
    if (shamt_i == '0)
      a_r8_zero_amount: assert (data_o == data_i)
        else $error("R8 zero distance altered the word");
    if (op_i > 3'b100)
      a_r7_undefined_pass: assert (data_o == data_i)
        else $error("R7 undefined op altered the word");
    if (op_i == 3'b011)
      a_r5_rol_keeps_ones: assert ($countones(data_o) == $countones(data_i))
        else $error("R5 left rotate lost bits");
    if (op_i == 3'b100)
      a_r6_ror_keeps_ones: assert ($countones(data_o) == $countones(data_i))
        else $error("R6 right rotate lost bits");
    if (op_i == 3'b000 && shamt_i != '0)
      a_r2_sll_zero_lsb: assert (data_o[0] == 1'b0)
        else $error("R2 left shift LSB not zero");
    if (op_i == 3'b001 && shamt_i != '0)
      a_r3_srl_zero_msb: assert (data_o[WIDTH-1] == 1'b0)
        else $error("R3 logical right shift MSB not zero");
    if (op_i == 3'b010)
      a_r4_sra_keeps_sign: assert (data_o[WIDTH-1] == data_i[WIDTH-1])
        else $error("R4 arithmetic shift changed sign");
  end

endmodule

bind shf_unit shf_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .data_i  (data_i),
  .shamt_i (shamt_i),
  .op_i    (op_i),
  .data_o  (data_o)
);

// File: tb/tb_shf_unit.sv
module tb_shf_unit;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int WATCHDOG   = 50000;

  logic         clk = 1'b0;
  logic [W-1:0] data_i;
  logic [4:0]   shamt_i;
  logic [2:0]   op_i;
  logic [W-1:0] data_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shf_unit #(.WIDTH(W)) dut (
    .data_i  (data_i),
    .shamt_i (shamt_i),
    .op_i    (op_i),
    .data_o  (data_o)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] d, int a, int op);
    case (op)
      0: return d << a;
      1: return d >> a;
      2: return W'($signed(d) >>> a);
      3: return (d << a) | (d >> (W - a));
      4: return (d >> a) | (d << (W - a));
      default: return d;
    endcase
  endfunction

  function automatic string req_tag(int a, int op);
    if (op > 4)  return "R7";
    if (a == 0)  return "R8";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(logic [W-1:0] d, int a, int op, string tag);
    logic [W-1:0] exp;
    @(negedge clk);
    data_i  = d;
    shamt_i = a[4:0];
    op_i    = op[2:0];
    exp     = model(d, a, op);
    @(posedge clk);
    checks++;
    if (data_o !== exp) begin
      errors++;
      $display("FAIL %s op=%0d amt=%0d data=%h actual=%h expected=%h",
               tag, op, a, d, data_o, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [W-1:0] pats [6];

  initial begin
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hAAAA_5555;
    pats[3] = 32'hDEAD_BEEF;
    pats[4] = 32'h1234_5678;
    pats[5] = 32'hFFFF_FFFF;

    // Idle state: all-zero inputs give all-zero output (R8)
    apply('0, 0, 0, "R8");

    // R1: single-stage distances isolate each layer
    for (int k = 0; k < 5; k++) begin
      apply(32'h0000_0001, 1 << k, 0, "R1");
      apply(32'h8000_0000, 1 << k, 2, "R1");
    end
    // R1: combined stages add their distances
    apply(32'h0000_0001, 5'b10101, 0, "R1");
    apply(32'h8000_0000, 5'b01011, 1, "R1");

    // Exhaustive sweep of operations and distances
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 6; p++)
          apply(pats[p], a, op, req_tag(a, op));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule